// File: doc/BRIEF.md
# Program Counter and Branch Unit

This block holds the program counter of a small 8-bit processor and decides, once per completed instruction, where execution goes next. The decode stage presents an instruction class, its length, its operand bytes and the condition field together with the current flags. The unit then either advances the counter by the instruction length or redirects it. The redirect sources are the address in the operand bytes, a popped return address, a fixed restart vector, or the HL register pair.

For subroutine calls and restarts the unit asks the stack logic outside it to push the return address, and tells it how far to move the stack pointer. For returns it asks for a pop and takes the popped value, which arrives in the same cycle, as the new counter. It also owns the interrupt-enable state. Disabling takes effect at once. Enabling is held off until the instruction after the enable has finished. The unit never writes a flag.

Top module: `pc_branch_unit`

## Requirements
- R1: While `rst_ni` is low and after it is released, `pc_o` is 0x0000 and `int_accept_o` is 0.
- R2: A completed instruction of class SEQ (cls_i = 0) sets `pc_o` to the old value plus `len_i` (1 to 3), modulo 2^AW, with no push or pop.
- R3: The condition field selects a flag and a required value: cond[2:1] picks Z (00), CY (01), P (10) or S (11), and the condition holds when that flag equals cond[0]. Flags are packed as `flags_i` = {S, Z, P, CY}. `taken_o` reports the outcome for a conditional instruction.
- R4: JMP (cls_i = 1) loads `pc_o` with {byte3, byte2}. When `cond_en_i` is 0 the jump is always taken.
- R5: A conditional JMP, CALL or RET whose condition is false advances `pc_o` by `len_i`, keeps `taken_o` at 0 and makes no stack request.
- R6: A taken CALL (cls_i = 2) raises `push_req_o` with `push_data_o` equal to the address of the next instruction and `sp_adj_o` = -2 (4'hE), and loads {byte3, byte2}.
- R7: A taken RET (cls_i = 3) raises `pop_req_o` with `sp_adj_o` = +2 and loads `pc_o` from `pop_data_i`.
- R8: RST (cls_i = 4) pushes the next address like a call and loads `pc_o` with 8 × `rst_num_i`.
- R9: PCHL (cls_i = 5) loads `pc_o` from `hl_i` with no stack request.
- R10: After EI (cls_i = 6), `int_accept_o` stays 0 until the following instruction has completed, and then reads 1.
- R11: DI (cls_i = 7) clears `int_accept_o` from its own completion onward. `int_accept_o` is 0 in any cycle in which an EI or DI is completing.
- R12: With `step_i` low, `pc_o` holds and no push, pop or taken indication is given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| step_i | input | 1 | Current instruction completes this cycle |
| cls_i | input | 3 | Instruction class |
| cond_en_i | input | 1 | Instruction is conditional |
| cond_i | input | 3 | Condition field |
| flags_i | input | 4 | {S, Z, P, CY} |
| len_i | input | 2 | Instruction length in bytes |
| byte2_i | input | 8 | Second instruction byte (target low) |
| byte3_i | input | 8 | Third instruction byte (target high) |
| rst_num_i | input | 3 | Restart vector number |
| hl_i | input | AW | HL register pair |
| pop_data_i | input | AW | Value popped from the stack |
| pc_o | output | AW | Program counter |
| taken_o | output | 1 | Transfer taken this cycle |
| push_req_o | output | 1 | Push request |
| push_data_o | output | AW | Value to push |
| pop_req_o | output | 1 | Pop request |
| sp_adj_o | output | 4 | Stack pointer adjustment, two's complement |
| int_accept_o | output | 1 | Interrupt may be accepted |

## Verification
The bench builds the unit with its default 16-bit address width and a restart stride of 8. This full address range lets sequential advance wrap from 0xFFFF and 0xFFFE back to the bottom of memory. It also puts the highest restart vector, 0x38, and full 16-bit targets from operand bytes, HL and the stack within reach. All eight condition codes are driven with their flag both set and clear, so each one is seen both taken and not taken.

// File: rtl/pcb_pkg.sv
package pcb_pkg;
  typedef enum logic [2:0] {
    CLS_SEQ  = 3'd0,
    CLS_JMP  = 3'd1,
    CLS_CALL = 3'd2,
    CLS_RET  = 3'd3,
    CLS_RST  = 3'd4,
    CLS_PCHL = 3'd5,
    CLS_EI   = 3'd6,
    CLS_DI   = 3'd7
  } pcb_cls_e;

  localparam int FLAG_CY = 0;
  localparam int FLAG_P  = 1;
  localparam int FLAG_Z  = 2;
  localparam int FLAG_S  = 3;
  localparam int FLAG_W  = 4;
  localparam int SPADJ_W = 4;
  localparam logic [SPADJ_W-1:0] SP_DOWN2 = 4'hE;
  localparam logic [SPADJ_W-1:0] SP_UP2   = 4'h2;
endpackage

// File: rtl/pcb_cond_eval.sv
module pcb_cond_eval
  import pcb_pkg::*;
(
  input  logic [2:0]        cond_i,
  input  logic [FLAG_W-1:0] flags_i,
  output logic              met_o
);
  logic sel_flag;

  always_comb begin
    unique case (cond_i[2:1])
      2'b00:   sel_flag = flags_i[FLAG_Z];
      2'b01:   sel_flag = flags_i[FLAG_CY];
      2'b10:   sel_flag = flags_i[FLAG_P];
      default: sel_flag = flags_i[FLAG_S];
    endcase
  end

  // low bit of the field is the flag value required
  assign met_o = (sel_flag == cond_i[0]);
endmodule

// File: rtl/pcb_next_pc.sv
module pcb_next_pc
  import pcb_pkg::*;
#(
  parameter int AW        = 16,
  parameter int VEC_SHIFT = 3
) (
  input  logic               step_i,
  input  logic [2:0]         cls_i,
  input  logic               cond_en_i,
  input  logic               cond_met_i,
  input  logic [1:0]         len_i,
  input  logic [7:0]         byte2_i,
  input  logic [7:0]         byte3_i,
  input  logic [2:0]         rst_num_i,
  input  logic [AW-1:0]      hl_i,
  input  logic [AW-1:0]      pop_data_i,
  input  logic [AW-1:0]      pc_i,
  output logic [AW-1:0]      pc_next_o,
  output logic               taken_o,
  output logic               push_req_o,
  output logic [AW-1:0]      push_data_o,
  output logic               pop_req_o,
  output logic [SPADJ_W-1:0] sp_adj_o
);
  pcb_cls_e cls;
  logic [AW-1:0] seq_pc, imm_pc, vec_pc;
  logic          xfer;

  assign cls    = pcb_cls_e'(cls_i);
  assign seq_pc = pc_i + AW'(len_i);
  assign imm_pc = AW'({byte3_i, byte2_i});
  assign vec_pc = AW'(rst_num_i) << VEC_SHIFT;

  always_comb begin
    unique case (cls)
      CLS_JMP, CLS_CALL, CLS_RET: xfer = cond_en_i ? cond_met_i : 1'b1;
      CLS_RST, CLS_PCHL:          xfer = 1'b1;
      default:                    xfer = 1'b0;
    endcase
  end

  assign taken_o     = step_i & xfer;
  assign push_req_o  = taken_o & ((cls == CLS_CALL) | (cls == CLS_RST));
  assign pop_req_o   = taken_o & (cls == CLS_RET);
  assign push_data_o = seq_pc;

  always_comb begin
    if (push_req_o)     sp_adj_o = SP_DOWN2;
    else if (pop_req_o) sp_adj_o = SP_UP2;
    else                sp_adj_o = '0;
  end

  always_comb begin
    pc_next_o = pc_i;
    if (step_i) begin
      pc_next_o = seq_pc;
      if (xfer) begin
        unique case (cls)
          CLS_JMP, CLS_CALL: pc_next_o = imm_pc;
          CLS_RET:           pc_next_o = pop_data_i;
          CLS_RST:           pc_next_o = vec_pc;
          CLS_PCHL:          pc_next_o = hl_i;
          default:           pc_next_o = seq_pc;
        endcase
      end
    end
  end
endmodule

// File: rtl/pcb_int_ctrl.sv
module pcb_int_ctrl
  import pcb_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       step_i,
  input  logic [2:0] cls_i,
  output logic       accept_o
);
  logic ie_q, hold_q, is_ei, is_di;

  assign is_ei = (cls_i == CLS_EI);
  assign is_di = (cls_i == CLS_DI);

  // hold_q masks acceptance until the instruction after EI completes
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ie_q   <= 1'b0;
      hold_q <= 1'b0;
    end else if (step_i) begin
      if (is_di) begin
        ie_q   <= 1'b0;
        hold_q <= 1'b0;
      end else if (is_ei) begin
        ie_q   <= 1'b1;
        hold_q <= 1'b1;
      end else begin
        hold_q <= 1'b0;
      end
    end
  end

  assign accept_o = ie_q & ~hold_q & ~(step_i & (is_ei | is_di));
endmodule

// File: rtl/pc_branch_unit.sv
module pc_branch_unit
  import pcb_pkg::*;
#(
  parameter int AW        = 16,
  parameter int VEC_SHIFT = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               step_i,
  input  logic [2:0]         cls_i,
  input  logic               cond_en_i,
  input  logic [2:0]         cond_i,
  input  logic [3:0]         flags_i,
  input  logic [1:0]         len_i,
  input  logic [7:0]         byte2_i,
  input  logic [7:0]         byte3_i,
  input  logic [2:0]         rst_num_i,
  input  logic [AW-1:0]      hl_i,
  input  logic [AW-1:0]      pop_data_i,
  output logic [AW-1:0]      pc_o,
  output logic               taken_o,
  output logic               push_req_o,
  output logic [AW-1:0]      push_data_o,
  output logic               pop_req_o,
  output logic [3:0]         sp_adj_o,
  output logic               int_accept_o
);
  logic [AW-1:0] pc_q, pc_d;
  logic          cond_met;

  pcb_cond_eval u_cond (
    .cond_i  (cond_i),
    .flags_i (flags_i),
    .met_o   (cond_met)
  );

  pcb_next_pc #(.AW(AW), .VEC_SHIFT(VEC_SHIFT)) u_next (
    .step_i      (step_i),
    .cls_i       (cls_i),
    .cond_en_i   (cond_en_i),
    .cond_met_i  (cond_met),
    .len_i       (len_i),
    .byte2_i     (byte2_i),
    .byte3_i     (byte3_i),
    .rst_num_i   (rst_num_i),
    .hl_i        (hl_i),
    .pop_data_i  (pop_data_i),
    .pc_i        (pc_q),
    .pc_next_o   (pc_d),
    .taken_o     (taken_o),
    .push_req_o  (push_req_o),
    .push_data_o (push_data_o),
    .pop_req_o   (pop_req_o),
    .sp_adj_o    (sp_adj_o)
  );

  pcb_int_ctrl u_int (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .step_i   (step_i),
    .cls_i    (cls_i),
    .accept_o (int_accept_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_q <= '0;
    else         pc_q <= pc_d;
  end

  assign pc_o = pc_q;
endmodule

// File: rtl/pcb_checker.sv
module pcb_checker #(
  parameter int AW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          step_i,
  input logic [2:0]    cls_i,
  input logic [1:0]    len_i,
  input logic [AW-1:0] hl_i,
  input logic [AW-1:0] pop_data_i,
  input logic [AW-1:0] pc_o,
  input logic          taken_o,
  input logic          push_req_o,
  input logic [AW-1:0] push_data_o,
  input logic          pop_req_o,
  input logic [3:0]    sp_adj_o,
  input logic          int_accept_o
);
  p_reset_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (pc_o == '0) && !int_accept_o);

  p_seq_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && cls_i == 3'd0) |=> pc_o == ($past(pc_o) + AW'($past(len_i))));

  p_push_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_req_o |-> (push_data_o == pc_o + AW'(len_i)) && (sp_adj_o == 4'hE) && !pop_req_o);

  p_pop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_req_o |=> pc_o == $past(pop_data_i));

  p_pchl_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && cls_i == 3'd5) |=> pc_o == $past(hl_i));

  p_di_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && cls_i == 3'd7) |-> !int_accept_o ##1 !int_accept_o);

  p_idle_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |-> !taken_o && !push_req_o && !pop_req_o ##1 $stable(pc_o));
endmodule

bind pc_branch_unit pcb_checker #(.AW(AW)) u_pcb_checker (.*);

// File: tb/pc_branch_unit_tb_top.sv
`timescale 1ns/1ps
module pc_branch_unit_tb_top;
  localparam int AW = 16;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          step_i = 1'b0;
  logic [2:0]    cls_i = '0;
  logic          cond_en_i = 1'b0;
  logic [2:0]    cond_i = '0;
  logic [3:0]    flags_i = '0;
  logic [1:0]    len_i = 2'd1;
  logic [7:0]    byte2_i = '0, byte3_i = '0;
  logic [2:0]    rst_num_i = '0;
  logic [AW-1:0] hl_i = '0, pop_data_i = '0;
  logic [AW-1:0] pc_o, push_data_o;
  logic          taken_o, push_req_o, pop_req_o, int_accept_o;
  logic [3:0]    sp_adj_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2 clk_i = ~clk_i;

  pc_branch_unit #(.AW(AW)) dut_i (.*);

  typedef struct {
    string         req;
    logic [AW-1:0] exp_pc;
    logic          exp_taken, got_taken;
    logic          exp_push, got_push;
    logic [AW-1:0] exp_pdata, got_pdata;
    logic          exp_pop, got_pop;
    logic [3:0]    exp_adj, got_adj;
    logic          exp_acc_now, got_acc_now;
    logic          exp_acc_after;
  } item_t;

  item_t sb_q[$];

  // reference state
  logic [AW-1:0] m_pc = '0;
  logic          m_ie = 0, m_hold = 0;

  task automatic check(string req, string what, logic [AW-1:0] got, logic [AW-1:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  function automatic logic cond_ok(logic [2:0] c, logic [3:0] f);
    logic v;
    case (c[2:1])
      2'b00: v = f[2];
      2'b01: v = f[0];
      2'b10: v = f[1];
      default: v = f[3];
    endcase
    return v == c[0];
  endfunction

  task automatic exec(input logic [2:0] cls, input logic cen, input logic [2:0] cnd,
                      input logic [3:0] flg, input logic [1:0] len,
                      input logic [7:0] b2, input logic [7:0] b3, input logic [2:0] rn,
                      input logic [AW-1:0] hl, input logic [AW-1:0] popd, input string req);
    item_t it;
    logic xfer;
    logic [AW-1:0] seq;
    @(negedge clk_i);
    cls_i = cls; cond_en_i = cen; cond_i = cnd; flags_i = flg; len_i = len;
    byte2_i = b2; byte3_i = b3; rst_num_i = rn; hl_i = hl; pop_data_i = popd;
    step_i = 1'b1;
    seq = m_pc + AW'(len);
    case (cls)
      3'd1, 3'd2, 3'd3: xfer = cen ? cond_ok(cnd, flg) : 1'b1;
      3'd4, 3'd5:       xfer = 1'b1;
      default:          xfer = 1'b0;
    endcase
    it.req       = req;
    it.exp_taken = xfer;
    it.exp_push  = xfer && (cls == 3'd2 || cls == 3'd4);
    it.exp_pop   = xfer && (cls == 3'd3);
    it.exp_pdata = it.exp_push ? seq : push_data_o;
    it.exp_adj   = it.exp_push ? 4'hE : (it.exp_pop ? 4'h2 : 4'h0);
    it.exp_acc_now = m_ie && !m_hold && !(cls == 3'd6 || cls == 3'd7);
    if (!xfer) it.exp_pc = seq;
    else case (cls)
      3'd3:    it.exp_pc = popd;
      3'd4:    it.exp_pc = AW'(rn) * 8;
      3'd5:    it.exp_pc = hl;
      default: it.exp_pc = {b3, b2};
    endcase
    if (cls == 3'd7) begin m_ie = 0; m_hold = 0; end
    else if (cls == 3'd6) begin m_ie = 1; m_hold = 1; end
    else m_hold = 0;
    it.exp_acc_after = m_ie && !m_hold;
    m_pc = it.exp_pc;
    #1;
    it.got_taken = taken_o; it.got_push = push_req_o; it.got_pdata = push_data_o;
    it.got_pop = pop_req_o; it.got_adj = sp_adj_o; it.got_acc_now = int_accept_o;
    if (!it.exp_push) it.exp_pdata = push_data_o;
    sb_q.push_back(it);
    @(posedge clk_i);
    #0.5;
    step_i = 1'b0;
  endtask

  task automatic idle(input string req);
    item_t it;
    @(negedge clk_i);
    step_i = 1'b0;
    #1;
    it.req = req; it.exp_pc = m_pc;
    it.exp_taken = 0; it.exp_push = 0; it.exp_pop = 0; it.exp_adj = 0;
    it.exp_pdata = push_data_o;
    it.exp_acc_now = m_ie && !m_hold; it.exp_acc_after = m_ie && !m_hold;
    it.got_taken = taken_o; it.got_push = push_req_o; it.got_pdata = push_data_o;
    it.got_pop = pop_req_o; it.got_adj = sp_adj_o; it.got_acc_now = int_accept_o;
    sb_q.push_back(it);
  endtask

  // monitor: compares after each edge
  initial begin
    item_t it;
    forever begin
      @(posedge clk_i);
      #1;
      if (sb_q.size() > 0) begin
        it = sb_q.pop_front();
        check(it.req, "taken", AW'(it.got_taken), AW'(it.exp_taken));
        check(it.req, "push", AW'(it.got_push), AW'(it.exp_push));
        check(it.req, "push_data", it.got_pdata, it.exp_pdata);
        check(it.req, "pop", AW'(it.got_pop), AW'(it.exp_pop));
        check(it.req, "sp_adj", AW'(it.got_adj), AW'(it.exp_adj));
        check(it.req, "accept_during", AW'(it.got_acc_now), AW'(it.exp_acc_now));
        check(it.req, "pc", pc_o, it.exp_pc);
        check(it.req, "accept_after", AW'(int_accept_o), AW'(it.exp_acc_after));
      end
    end
  end

  initial begin
    #40000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    #5;
    check("R1", "pc in reset", pc_o, '0);
    check("R1", "accept in reset", AW'(int_accept_o), '0);
    @(negedge clk_i); @(negedge clk_i);
    rst_ni = 1'b1;
    @(posedge clk_i); #1;
    check("R1", "pc after reset", pc_o, '0);
    check("R1", "accept after reset", AW'(int_accept_o), '0);

    // R2 sequential advance
    exec(3'd0, 0, 0, 4'h0, 2'd1, 0, 0, 0, 0, 0, "R2");
    exec(3'd0, 0, 0, 4'h0, 2'd2, 0, 0, 0, 0, 0, "R2");
    exec(3'd0, 0, 0, 4'h0, 2'd3, 0, 0, 0, 0, 0, "R2");
    // R4 unconditional jump, then R2 wrap
    exec(3'd1, 0, 0, 4'h0, 2'd3, 8'hFF, 8'hFF, 0, 0, 0, "R4");
    exec(3'd0, 0, 0, 4'h0, 2'd1, 0, 0, 0, 0, 0, "R2");
    exec(3'd1, 0, 0, 4'h0, 2'd3, 8'hFE, 8'hFF, 0, 0, 0, "R4");
    exec(3'd0, 0, 0, 4'h0, 2'd3, 0, 0, 0, 0, 0, "R2");
    // R3 all condition codes, flag set and clear
    for (int c = 0; c < 8; c++) begin
      exec(3'd1, 1, 3'(c), 4'hF, 2'd3, 8'(8'h10 + c), 8'h12, 0, 0, 0, "R3");
      exec(3'd1, 1, 3'(c), 4'h0, 2'd3, 8'(8'h20 + c), 8'h34, 0, 0, 0, "R3");
    end
    // R5 false conditional jump (Z required, Z clear)
    exec(3'd1, 1, 3'd1, 4'hB, 2'd3, 8'h00, 8'h80, 0, 0, 0, "R5");
    // R6 call taken and not taken
    exec(3'd2, 0, 0, 4'h0, 2'd3, 8'h56, 8'h40, 0, 0, 0, "R6");
    exec(3'd2, 1, 3'd3, 4'h1, 2'd3, 8'h78, 8'h41, 0, 0, 0, "R6");
    exec(3'd2, 1, 3'd3, 4'h0, 2'd3, 8'h78, 8'h42, 0, 0, 0, "R5");
    // R7 return taken; conditional return false
    exec(3'd3, 0, 0, 4'h0, 2'd1, 0, 0, 0, 0, 16'hBEEF, "R7");
    exec(3'd3, 1, 3'd7, 4'h8, 2'd1, 0, 0, 0, 0, 16'h1357, "R7");
    exec(3'd3, 1, 3'd6, 4'h8, 2'd1, 0, 0, 0, 0, 16'h2468, "R5");
    // R8 restart vectors
    exec(3'd4, 0, 0, 4'h0, 2'd1, 0, 0, 3'd5, 0, 0, "R8");
    exec(3'd4, 0, 0, 4'h0, 2'd1, 0, 0, 3'd7, 0, 0, "R8");
    exec(3'd4, 0, 0, 4'h0, 2'd1, 0, 0, 3'd0, 0, 0, "R8");
    // R9 jump via HL
    exec(3'd5, 0, 0, 4'h0, 2'd1, 0, 0, 0, 16'hC0DE, 0, "R9");
    // R12 idle cycles hold
    idle("R12");
    idle("R12");
    // R10 enable delay
    exec(3'd6, 0, 0, 4'h0, 2'd1, 0, 0, 0, 0, 0, "R10");
    idle("R10");
    exec(3'd0, 0, 0, 4'h0, 2'd2, 0, 0, 0, 0, 0, "R10");
    idle("R10");
    // R11 disable immediate, enable mask during EI
    exec(3'd6, 0, 0, 4'h0, 2'd1, 0, 0, 0, 0, 0, "R11");
    exec(3'd7, 0, 0, 4'h0, 2'd1, 0, 0, 0, 0, 0, "R11");
    exec(3'd0, 0, 0, 4'h0, 2'd1, 0, 0, 0, 0, 0, "R11");
    exec(3'd6, 0, 0, 4'h0, 2'd1, 0, 0, 0, 0, 0, "R10");
    exec(3'd1, 0, 0, 4'h0, 2'd3, 8'h00, 8'h90, 0, 0, 0, "R10");
    exec(3'd7, 0, 0, 4'h0, 2'd1, 0, 0, 0, 0, 0, "R11");
    idle("R11");
    repeat (3) @(posedge clk_i);
    #1;
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule